// File: doc/BRIEF.md
# Serial Clock-Enable Control Register Slave

This block is a two-wire serial slave that keeps a small bank of 8-bit control registers, each bit of which enables one clock output of a clock generator. A host changes the bank with a block write. The write carries the fixed device address, a command code of zero and a byte count. The data bytes that follow fill the registers strictly in order from register 0. Reaching a later register therefore means resending every byte before it. A read at the companion address returns the register count and then the stored bytes, so the host can confirm what it wrote.

The serial clock and data pins are sampled by a fast system clock through two-flop synchronizers. Start, stop and the clock edges are recovered in that domain. The slave never drives the data line high: it only asserts an open-drain pull-down enable. After reset, every register holds its default of all-ones, which enables every output. Using the serial port is therefore optional.

Top module: `smb_ctrl_regs`

## Requirements
- R1: The slave reacts only after a start condition (data falling while clock is high). Bytes clocked without a preceding start are not acknowledged, and a stop (data rising while clock is high) returns it to idle.
- R2: After reset every register reads 0xFF and `sda_pull` is 0.
- R3: Bytes move MSB first, 8 bits and then an acknowledge bit. A write address byte of 0xD2 and a following command byte of 0x00 are each acknowledged by holding `sda_pull` high through the ninth clock.
- R4: If the address byte is neither 0xD2 nor 0xD3, or the command byte is not 0x00, that byte is not acknowledged. Every byte after it is ignored and not acknowledged, and no register changes, until the next start or stop.
- R5: In a write, the third byte is a byte count. Each later data byte is acknowledged, and the k-th data byte (k from 0) is stored into register k.
- R6: Data bytes at position k are acknowledged but discarded when k is not below both the byte count and the register count NREGS (default 6).
- R7: After an acknowledged address byte of 0xD3, the slave sends, MSB first, first the value NREGS, then registers 0, 1, 2 and so on in order. Any byte after the last register reads 0xFF.
- R8: When the host does not acknowledge a read byte, the slave releases the data line and keeps it released until the next start.
- R9: `sda_pull` and the register outputs change only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level (wired line) |
| sda_pull | output | 1 | Open-drain enable; 1 pulls the data line low |
| ctrl_regs | output | NREGS*8 | Register contents, register k in bits [8k+7:8k] |

## Verification
On every cycle, the assertions check that the pull-down and the register outputs move only while the serial clock is low. They also check that a start always re-arms the byte counter, that the line stays released while the slave is idle or ignoring the bus, and that no register changes in those states. Only the bench scenarios can show the byte-level meaning: which bytes get an acknowledge, which data bytes land in which register under a given byte count, what the read stream contains, and that a host NACK frees the line for the rest of the transfer.

// File: rtl/smb_ctrl_regs.sv
module smb_ctrl_regs #(
  parameter int NREGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] CMD_CODE = 8'h00,
  parameter logic [7:0] RESET_VAL = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull,
  output logic [NREGS*8-1:0] ctrl_regs
);
  localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_ADDR = {DEV_ADDR, 1'b1};
  localparam logic [7:0] NBYTE   = 8'(NREGS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD, S_SKIP} st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] rx, tx, idx, bcnt, rd_byte;
  logic       mack;
  logic [7:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl      = scl_q[1];
  wire scl_p    = scl_q[2];
  wire sda      = sda_q[1];
  wire sda_p    = sda_q[2];
  wire scl_rise = scl & ~scl_p;
  wire scl_fall = ~scl & scl_p;
  wire start    = scl & scl_p & sda_p & ~sda;
  wire stop     = scl & scl_p & ~sda_p & sda;
  wire quiet    = (st == S_IDLE) || (st == S_SKIP);
  wire wr_hit   = (st == S_WR) && scl_fall && (cnt == 4'd8) && (idx < bcnt);

  always_comb begin
    rd_byte = 8'hFF;
    if (idx == 8'd0) rd_byte = NBYTE;
    for (int i = 0; i < NREGS; i++)
      if (idx == 8'(i + 1)) rd_byte = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      rx       <= '0;
      tx       <= '0;
      idx      <= '0;
      bcnt     <= '0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start) begin
      st       <= S_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop) begin
      st       <= S_IDLE;
      sda_pull <= 1'b0;
    end else if (scl_rise && !quiet) begin
      if (cnt < 4'd9) cnt <= cnt + 4'd1;
      if (cnt < 4'd8) rx <= {rx[6:0], sda};
      if (cnt == 4'd8) mack <= ~sda;
    end else if (scl_fall && !quiet) begin
      if (cnt == 4'd8) begin
        if (st == S_RD) sda_pull <= 1'b0;
        else begin
          case (st)
            S_ADDR:
              if (rx == WR_ADDR) begin
                st <= S_CMD; sda_pull <= 1'b1;
              end else if (rx == RD_ADDR) begin
                st <= S_RD; idx <= '0; sda_pull <= 1'b1;
              end else st <= S_SKIP;
            S_CMD:
              if (rx == CMD_CODE) begin
                st <= S_CNT; sda_pull <= 1'b1;
              end else st <= S_SKIP;
            S_CNT: begin
              bcnt <= rx; idx <= '0; st <= S_WR; sda_pull <= 1'b1;
            end
            default: begin
              if (idx != 8'hFF) idx <= idx + 8'd1;
              sda_pull <= 1'b1;
            end
          endcase
        end
      end else if (cnt == 4'd9) begin
        cnt <= '0;
        if (st == S_RD) begin
          if (mack) begin
            tx       <= rd_byte;
            sda_pull <= ~rd_byte[7];
            if (idx != 8'hFF) idx <= idx + 8'd1;
          end else begin
            st       <= S_SKIP;
            sda_pull <= 1'b0;
          end
        end else sda_pull <= 1'b0;
      end else if (cnt != 4'd0 && st == S_RD) begin
        tx       <= {tx[6:0], 1'b0};
        sda_pull <= ~tx[6];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= RESET_VAL;
    end else begin
      for (int i = 0; i < NREGS; i++)
        if (wr_hit && idx == 8'(i)) regs[i] <= rx;
    end

  generate
    for (genvar g = 0; g < NREGS; g++) begin : g_out
      assign ctrl_regs[g*8 +: 8] = regs[g];
    end
  endgenerate
endmodule

module smb_ctrl_regs_chk #(
  parameter int NREGS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_pull,
  input logic [NREGS*8-1:0] ctrl_regs,
  input logic               start,
  input logic               quiet,
  input logic [3:0]         cnt
);
  p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_i);
  p_regs_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_regs) |-> !scl_i);
  p_start_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == 4'd0 && !quiet));
  p_quiet_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !sda_pull);
  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(quiet) |-> $stable(ctrl_regs));
endmodule

bind smb_ctrl_regs smb_ctrl_regs_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull(sda_pull),
  .ctrl_regs(ctrl_regs), .start(start), .quiet(quiet), .cnt(cnt)
);

// File: tb/smb_ctrl_regs_bench.sv
module smb_ctrl_regs_bench;
  localparam int N = 6;
  localparam int H = 16;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [N*8-1:0] ctrl_regs;
  wire sda_bus = sda_m & ~sda_pull;

  int checks = 0, fails = 0;
  logic [7:0] expv [N];
  logic [7:0] dat [12];

  always #2.5 clk = ~clk;

  smb_ctrl_regs u_smb_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull(sda_pull), .ctrl_regs(ctrl_regs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(2*H);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    logic r2;
    sda_m = b; hw(H);
    scl_m = 1'b1; hw(H/2); r = sda_bus; hw(H/2); r2 = sda_bus;
    if (r !== r2) chk("R9 line steady in high phase", 32'(r2), 32'(r));
    scl_m = 1'b0; hw(H/2);
  endtask

  function automatic logic [7:0] ref_byte(input int k);
    if (k == 0) return 8'(N);
    if (k <= N) return expv[k-1];
    return 8'hFF;
  endfunction

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); b[i] = r; end
    clk_bit(~give_ack, r);
  endtask

  task automatic block_write(input logic [7:0] adr, input logic [7:0] cmd,
                             input int cnt, input int nd, input int exp_stage, input string req);
    logic a;
    bus_start;
    send_byte(adr, a); chk({req, " address ack"}, 32'(a), 32'(exp_stage >= 1));
    send_byte(cmd, a); chk({req, " command ack"}, 32'(a), 32'(exp_stage >= 2));
    send_byte(8'(cnt), a); chk({req, " count ack"}, 32'(a), 32'(exp_stage >= 2));
    for (int i = 0; i < nd; i++) begin
      send_byte(dat[i], a); chk({req, " data ack"}, 32'(a), 32'(exp_stage >= 2));
    end
    bus_stop;
    if (exp_stage >= 2)
      for (int i = 0; i < nd; i++) if (i < cnt && i < N) expv[i] = dat[i];
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < N; i++) chk(req, 32'(ctrl_regs[i*8 +: 8]), 32'(expv[i]));
  endtask

  task automatic read_all(input int nb);
    logic a, r;
    logic [7:0] b;
    bus_start;
    send_byte(8'hD3, a); chk("R7 read address ack", 32'(a), 32'd1);
    for (int k = 0; k < nb; k++) begin
      recv_byte(k != nb - 1, b);
      chk("R7 read byte", 32'(b), 32'(ref_byte(k)));
    end
    clk_bit(1'b1, r); chk("R8 line released after NACK", 32'(r), 32'd1);
    chk("R8 no pull after NACK", 32'(sda_pull), 32'd0);
    bus_stop;
  endtask

  initial begin
    logic a;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) expv[i] = 8'hFF;
    hw(10); rst_n = 1'b1; hw(10);
    check_regs("R2 reset value");
    chk("R2 line released", 32'(sda_pull), 32'd0);

    for (int i = 0; i < 12; i++) dat[i] = 8'(8'h11 * (i + 1));
    block_write(8'hD2, 8'h00, N, N, 2, "R3 R5 full write");
    check_regs("R5 registers loaded in order");
    read_all(N + 2);

    for (int i = 0; i < 12; i++) dat[i] = 8'h00;
    block_write(8'hA0, 8'h00, N, N, 0, "R4 wrong address");
    check_regs("R4 wrong address leaves registers");
    block_write(8'hD2, 8'h05, N, N, 1, "R4 wrong command");
    check_regs("R4 wrong command leaves registers");

    for (int i = 0; i < 12; i++) dat[i] = 8'(8'hA5 ^ i);
    block_write(8'hD2, 8'h00, 2, 5, 2, "R6 short count");
    check_regs("R6 only counted bytes stored");
    block_write(8'hD2, 8'h00, 20, N + 3, 2, "R6 excess bytes");
    check_regs("R6 bytes past last register discarded");

    send_byte(8'hD2, a); chk("R1 no ack without start", 32'(a), 32'd0);
    send_byte(8'h00, a); chk("R1 no ack without start", 32'(a), 32'd0);
    bus_stop;
    check_regs("R1 registers kept without start");

    for (int t = 0; t < 12; t++) begin
      int c, n;
      c = int'($urandom_range(0, N + 2));
      n = int'($urandom_range(0, N + 2));
      for (int i = 0; i < 12; i++) dat[i] = 8'($urandom);
      block_write(8'hD2, 8'h00, c, n, 2, "R5 R6 random write");
      check_regs("R5 R6 random registers");
      read_all(int'($urandom_range(1, N + 2)));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule